// File: doc/BRIEF.md
# Split-Mode Address Translation Cache

This block caches the results of logical-to-physical page translation so that most memory accesses avoid a table walk. It is direct-mapped and keeps two independent entry arrays, one for user-mode accesses and one for supervisor-mode accesses. Each entry holds a tag, a signed physical offset and six flags: global, transparent, modified, write-protected, valid for data and valid for instruction fetch.

A requester presents a logical address, the privilege mode, the access type and the direction. One cycle later the block reports exactly one outcome: a hit with the physical address, a fault, or a request to refill. On a refill the surrounding logic consults the transparent-window matchers and the table walker, then hands the result back through the fill port. The fill logic turns that result into an entry. It handles four cases: a transparent-window hit, translation switched off, a refused descriptor, and a resident descriptor. Invalidation can target one index, or it can sweep every entry. Either kind can spare entries marked global. A two-bit control register switches translation on and selects 4 KB or 8 KB pages. Any write to this register clears the whole cache.

Top module: `atc_cache`

## Requirements
- R1: Asynchronous reset (rst_n low) invalidates every entry of both arrays, global ones included, and clears the control register, so any lookup after reset reports refill.
- R2: An entry is selected by address bits [17:12] and tagged with bits [31:18]. A lookup whose tag differs from the stored tag reports refill. An invalidated entry holds tag 0x8000, which no address produces.
- R3: A lookup accepted on one clock edge is answered on the next edge with rsp_valid high and exactly one of rsp_hit, rsp_fault or rsp_refill high. All four are low in a cycle that answers no lookup.
- R4: On a tag match, a lookup faults when the entry's valid flag for the access type is clear. lk_data=1 selects the data flag and lk_data=0 selects the instruction flag.
- R5: A write that matches an entry marked write-protected faults. Reads of the same entry still hit.
- R6: A write that matches a valid, unprotected entry whose modified flag is clear reports refill. A read of that entry hits.
- R7: With translation off and no transparent-window hit, a fill produces an entry that is valid for both access types, global, modified and unprotected. Lookups to it then hit with physical address equal to the logical address.
- R8: With translation on, a fill from a resident descriptor yields a physical address that takes the page bits of fill_pa and the in-page bits of the logical address. The page is 4 KB when tc_bits[0]=0 and 8 KB when tc_bits[0]=1. The global, modified and write-protect flags are copied from the descriptor.
- R9: With translation on, a fill is refused when fill_resident=0, or when fill_sup_only=1 and the fill is for user mode. The entry is then tagged but valid for neither access type, so a lookup faults.
- R10: A transparent-window fill (fill_ttr_hit=1) gives an untranslated, global, modified entry. Its write protection comes from fill_ttr_wp. It is valid for the fill's access type, and also for the other type when fill_ttr_both=1.
- R11: A flush by index invalidates the entry at fl_idx in the array that fl_super selects (1 = supervisor). In 8 KB mode it also invalidates the entry at fl_idx XOR 1. The other array is untouched.
- R12: Both flush by index and flush of all entries leave global entries valid unless fl_global=1.
- R13: tc_bits[1] switches translation on and tc_bits[0] selects 8 KB pages. Writing the register (tc_we) invalidates all entries, global ones included.
- R14: User and supervisor arrays are separate. A fill for one mode never makes a lookup in the other mode hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_we | input | 1 | Write the translation control register |
| tc_bits | input | 2 | [1] translation on, [0] 8 KB pages |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address of the lookup |
| lk_super | input | 1 | Lookup in supervisor mode |
| lk_data | input | 1 | 1 = data access, 0 = instruction fetch |
| lk_write | input | 1 | Lookup is for a write |
| fill_valid | input | 1 | Install a walker result |
| fill_addr | input | 32 | Logical address being filled |
| fill_super | input | 1 | Fill targets the supervisor array |
| fill_data | input | 1 | Access type that caused the fill |
| fill_ttr_hit | input | 1 | A transparent window matched |
| fill_ttr_both | input | 1 | The window also matches the other access type |
| fill_ttr_wp | input | 1 | The matching window is write-protected |
| fill_resident | input | 1 | Descriptor is resident |
| fill_pa | input | 32 | Physical page address from the descriptor |
| fill_glob | input | 1 | Descriptor global flag |
| fill_mod | input | 1 | Descriptor modified flag |
| fill_wp | input | 1 | Descriptor write-protect flag |
| fill_sup_only | input | 1 | Descriptor restricts the page to supervisor mode |
| fl_addr_valid | input | 1 | Flush by index |
| fl_all_valid | input | 1 | Flush every entry of both arrays |
| fl_global | input | 1 | Flush also removes global entries |
| fl_super | input | 1 | Array for flush by index |
| fl_idx | input | 6 | Index (address bits [17:12]) for flush by index |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation available |
| rsp_fault | output | 1 | Access not permitted |
| rsp_refill | output | 1 | Entry must be refilled |
| rsp_paddr | output | 32 | Physical address on a hit |

## Verification
On every cycle the assertions check three things. Each answer carries exactly one outcome. Idle cycles stay quiet. The first lookup after a control-register write or a full global flush asks for a refill. They also follow two fill-then-lookup pairs cycle by cycle: a write-protected transparent fill makes the next write fault, and a fill with translation off makes the next lookup hit with the logical address unchanged. The scenarios cover the behaviours that depend on earlier history. These include the flags copied from descriptors, 8 KB address formation, and the index pairing in 8 KB flushes. They also include global entries surviving selective flushes, the separation of the two modes, and faults from refused descriptors.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int ADDR_W   = 32;
  localparam int IDX_W    = 6;
  localparam int SHIFT_4K = 12;
  localparam int TAG_W    = 16;
  localparam int ENTRIES  = 1 << IDX_W;
  localparam logic [TAG_W-1:0] TAG_NONE = TAG_W'(16'h8000);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] off;
    logic              glob;
    logic              tt;
    logic              mod;
    logic              wp;
    logic              vd;
    logic              vi;
  } atc_ent_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] off;
    logic              tt;
    logic              mod;
    logic              wp;
    logic              vd;
    logic              vi;
  } atc_rd_t;

  localparam atc_ent_t ENT_EMPTY = '{tag: TAG_NONE, off: '0, glob: 1'b0,
                                     tt: 1'b0, mod: 1'b0, wp: 1'b0,
                                     vd: 1'b0, vi: 1'b0};

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[SHIFT_4K +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = a >> (SHIFT_4K + IDX_W);
    return t[TAG_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] page_base(input logic [ADDR_W-1:0] a,
                                                  input logic big);
    logic [ADDR_W-1:0] lowmask;
    lowmask = big ? ((ADDR_W'(1) << (SHIFT_4K + 1)) - ADDR_W'(1))
                  : ((ADDR_W'(1) << SHIFT_4K) - ADDR_W'(1));
    return a & ~lowmask;
  endfunction

  function automatic logic [ADDR_W-1:0] make_off(input logic [ADDR_W-1:0] pa,
                                                 input logic [ADDR_W-1:0] la,
                                                 input logic big);
    return page_base(pa, big) - page_base(la, big);
  endfunction
endpackage

// File: rtl/atc_fill_fmt.sv
module atc_fill_fmt
  import atc_pkg::*;
(
  input  logic              xlate_en,
  input  logic              big_page,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_super,
  input  logic              f_data,
  input  logic              f_ttr_hit,
  input  logic              f_ttr_both,
  input  logic              f_ttr_wp,
  input  logic              f_resident,
  input  logic [ADDR_W-1:0] f_pa,
  input  logic              f_glob,
  input  logic              f_mod,
  input  logic              f_wp,
  input  logic              f_sup_only,
  output atc_ent_t          ent
);
  logic refused;
  assign refused = !f_resident || (f_sup_only && !f_super);

  always_comb begin
    ent     = ENT_EMPTY;
    ent.tag = tag_of(f_addr);
    if (f_ttr_hit) begin
      ent.tt   = 1'b1;
      ent.vd   = f_data | f_ttr_both;
      ent.vi   = !f_data | f_ttr_both;
      ent.glob = 1'b1;
      ent.mod  = 1'b1;
      ent.wp   = f_ttr_wp;
    end else if (!xlate_en) begin
      ent.vd   = 1'b1;
      ent.vi   = 1'b1;
      ent.glob = 1'b1;
      ent.mod  = 1'b1;
    end else if (!refused) begin
      ent.vd   = 1'b1;
      ent.vi   = 1'b1;
      ent.off  = make_off(f_pa, f_addr, big_page);
      ent.glob = f_glob;
      ent.mod  = f_mod;
      ent.wp   = f_wp;
    end
  end
endmodule

// File: rtl/atc_bank.sv
module atc_bank
  import atc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_all,
  input  logic             kill_glob,
  input  logic             fl_en,
  input  logic             fl_glob,
  input  logic             fl_pair,
  input  logic [IDX_W-1:0] fl_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  atc_ent_t         fill_ent,
  input  logic [IDX_W-1:0] rd_idx,
  output atc_rd_t          rd_ent
);
  atc_ent_t [ENTRIES-1:0] view;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    atc_ent_t q;
    logic     pick, drop;
    assign pick = fl_en && ((fl_idx == IDX_W'(i)) ||
                            (fl_pair && ((fl_idx ^ IDX_W'(1)) == IDX_W'(i))));
    assign drop = (kill_all && (kill_glob || !q.glob)) ||
                  (pick && (fl_glob || !q.glob));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q     <= ENT_EMPTY;
      else if (drop)                             q.tag <= TAG_NONE;
      else if (fill_en && fill_idx == IDX_W'(i)) q     <= fill_ent;
    end
    assign view[i] = q;
  end

  always_comb begin
    rd_ent.tag = view[rd_idx].tag;
    rd_ent.off = view[rd_idx].off;
    rd_ent.tt  = view[rd_idx].tt;
    rd_ent.mod = view[rd_idx].mod;
    rd_ent.wp  = view[rd_idx].wp;
    rd_ent.vd  = view[rd_idx].vd;
    rd_ent.vi  = view[rd_idx].vi;
  end

  assert_kill_all_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_all && kill_glob) |=> (view[0].tag == TAG_NONE && view[ENTRIES-1].tag == TAG_NONE));
endmodule

// File: rtl/atc_cache.sv
module atc_cache
  import atc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tc_we,
  input  logic [1:0]        tc_bits,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_super,
  input  logic              lk_data,
  input  logic              lk_write,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_super,
  input  logic              fill_data,
  input  logic              fill_ttr_hit,
  input  logic              fill_ttr_both,
  input  logic              fill_ttr_wp,
  input  logic              fill_resident,
  input  logic [ADDR_W-1:0] fill_pa,
  input  logic              fill_glob,
  input  logic              fill_mod,
  input  logic              fill_wp,
  input  logic              fill_sup_only,
  input  logic              fl_addr_valid,
  input  logic              fl_all_valid,
  input  logic              fl_global,
  input  logic              fl_super,
  input  logic [IDX_W-1:0]  fl_idx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              rsp_refill,
  output logic [ADDR_W-1:0] rsp_paddr
);
  localparam int MODES = 2;

  logic xlate_en, big_page;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlate_en <= 1'b0;
      big_page <= 1'b0;
    end else if (tc_we) begin
      xlate_en <= tc_bits[1];
      big_page <= tc_bits[0];
    end
  end

  logic kill_all, kill_glob;
  assign kill_all  = tc_we | fl_all_valid;
  assign kill_glob = tc_we | fl_global;

  atc_ent_t fill_ent;
  atc_fill_fmt u_fmt (
    .xlate_en(xlate_en), .big_page(big_page), .f_addr(fill_addr),
    .f_super(fill_super), .f_data(fill_data), .f_ttr_hit(fill_ttr_hit),
    .f_ttr_both(fill_ttr_both), .f_ttr_wp(fill_ttr_wp),
    .f_resident(fill_resident), .f_pa(fill_pa), .f_glob(fill_glob),
    .f_mod(fill_mod), .f_wp(fill_wp), .f_sup_only(fill_sup_only),
    .ent(fill_ent)
  );

  atc_rd_t [MODES-1:0] bank_rd;
  for (genvar m = 0; m < MODES; m++) begin : g_mode
    atc_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .kill_all(kill_all), .kill_glob(kill_glob),
      .fl_en(fl_addr_valid && (fl_super == (m == 1))),
      .fl_glob(fl_global), .fl_pair(big_page), .fl_idx(fl_idx),
      .fill_en(fill_valid && (fill_super == (m == 1))),
      .fill_idx(idx_of(fill_addr)), .fill_ent(fill_ent),
      .rd_idx(idx_of(lk_addr)), .rd_ent(bank_rd[m])
    );
  end

  // Lookup decision, named for the checks below
  atc_rd_t           lk_ent;
  logic              lk_match, lk_type_ok, lk_wp_block, lk_need_mod;
  logic [ADDR_W-1:0] lk_pa;
  assign lk_ent      = bank_rd[lk_super];
  assign lk_match    = (lk_ent.tag == tag_of(lk_addr));
  assign lk_type_ok  = lk_data ? lk_ent.vd : lk_ent.vi;
  assign lk_wp_block = lk_write && lk_ent.wp;
  assign lk_need_mod = lk_write && !lk_ent.wp && !lk_ent.mod;
  assign lk_pa       = lk_ent.tt ? lk_addr : (lk_addr + lk_ent.off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_refill <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_refill <= lk_valid && (!lk_match || (lk_type_ok && lk_need_mod));
      rsp_fault  <= lk_valid && lk_match && (!lk_type_ok || lk_wp_block);
      rsp_hit    <= lk_valid && lk_match && lk_type_ok && !lk_wp_block && !lk_need_mod;
      rsp_paddr  <= lk_valid ? lk_pa : '0;
    end
  end

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault, rsp_refill}) == 1));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_fault || rsp_refill));

  assert_tc_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tc_we ##1 lk_valid |=> rsp_refill);

  assert_ttr_wp_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ttr_hit && fill_ttr_wp && !kill_all && !fl_addr_valid)
    ##1 (lk_valid && lk_write && lk_addr == $past(fill_addr) && lk_super == $past(fill_super))
    |=> rsp_fault);

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ttr_hit && !xlate_en && !kill_all && !fl_addr_valid)
    ##1 (lk_valid && lk_addr == $past(fill_addr) && lk_super == $past(fill_super))
    |=> (rsp_hit && rsp_paddr == $past(lk_addr)));
endmodule

// File: tb/atc_cache_bench.sv
module atc_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tc_we = 1'b0;
  logic [1:0]  tc_bits = '0;
  logic        lk_valid = 1'b0, lk_super = 1'b0, lk_data = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        fill_valid = 1'b0, fill_super = 1'b0, fill_data = 1'b0;
  logic        fill_ttr_hit = 1'b0, fill_ttr_both = 1'b0, fill_ttr_wp = 1'b0;
  logic        fill_resident = 1'b0, fill_glob = 1'b0, fill_mod = 1'b0;
  logic        fill_wp = 1'b0, fill_sup_only = 1'b0;
  logic [31:0] fill_addr = '0, fill_pa = '0;
  logic        fl_addr_valid = 1'b0, fl_all_valid = 1'b0, fl_global = 1'b0, fl_super = 1'b0;
  logic [5:0]  fl_idx = '0;
  logic        rsp_valid, rsp_hit, rsp_fault, rsp_refill;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit big = 1'b0;

  localparam int K_HIT = 0, K_FLT = 1, K_REF = 2;

  always #2 clk = ~clk;

  atc_cache u_atc_cache (
    .clk(clk), .rst_n(rst_n), .tc_we(tc_we), .tc_bits(tc_bits),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_super(lk_super),
    .lk_data(lk_data), .lk_write(lk_write),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_super(fill_super),
    .fill_data(fill_data), .fill_ttr_hit(fill_ttr_hit), .fill_ttr_both(fill_ttr_both),
    .fill_ttr_wp(fill_ttr_wp), .fill_resident(fill_resident), .fill_pa(fill_pa),
    .fill_glob(fill_glob), .fill_mod(fill_mod), .fill_wp(fill_wp),
    .fill_sup_only(fill_sup_only),
    .fl_addr_valid(fl_addr_valid), .fl_all_valid(fl_all_valid), .fl_global(fl_global),
    .fl_super(fl_super), .fl_idx(fl_idx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_refill(rsp_refill), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [31:0] expect_pa(input logic [31:0] la, input logic [31:0] pa,
                                            input bit b);
    return b ? {pa[31:13], la[12:0]} : {pa[31:12], la[11:0]};
  endfunction

  task automatic check(input string req, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a, input bit sup, input bit dat,
                      input bit wr, input int kind, input logic [31:0] pa);
    int got;
    lk_valid = 1'b1; lk_addr = a; lk_super = sup; lk_data = dat; lk_write = wr;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    if (!rsp_valid || (32'(rsp_hit) + 32'(rsp_fault) + 32'(rsp_refill)) != 1) got = 3;
    else if (rsp_hit) got = K_HIT;
    else if (rsp_fault) got = K_FLT;
    else got = K_REF;
    check(req, got == kind, 32'(got), 32'(kind));
    if (kind == K_HIT && got == K_HIT) check(req, rsp_paddr == pa, rsp_paddr, pa);
  endtask

  task automatic fill(input logic [31:0] a, input bit sup, input bit dat, input bit tth,
                      input bit tboth, input bit twp, input bit res, input logic [31:0] pa,
                      input bit g, input bit m, input bit wp, input bit so);
    fill_valid = 1'b1; fill_addr = a; fill_super = sup; fill_data = dat;
    fill_ttr_hit = tth; fill_ttr_both = tboth; fill_ttr_wp = twp; fill_resident = res;
    fill_pa = pa; fill_glob = g; fill_mod = m; fill_wp = wp; fill_sup_only = so;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic flush_idx(input logic [31:0] a, input bit sup, input bit g);
    fl_addr_valid = 1'b1; fl_idx = a[17:12]; fl_super = sup; fl_global = g;
    @(posedge clk);
    @(negedge clk);
    fl_addr_valid = 1'b0; fl_global = 1'b0;
  endtask

  task automatic flush_all(input bit g);
    fl_all_valid = 1'b1; fl_global = g;
    @(posedge clk);
    @(negedge clk);
    fl_all_valid = 1'b0; fl_global = 1'b0;
  endtask

  task automatic write_tc(input bit en, input bit b8);
    tc_we = 1'b1; tc_bits = {en, b8};
    @(posedge clk);
    @(negedge clk);
    tc_we = 1'b0;
    big = b8;
  endtask

  task automatic t_reset_state;
    check("R1 reset quiet", !rsp_valid && !rsp_hit && !rsp_fault && !rsp_refill,
          {28'd0, rsp_valid, rsp_hit, rsp_fault, rsp_refill}, 32'd0);
    look("R1 lookup after reset", 32'h0040_5123, 1'b0, 1'b1, 1'b0, K_REF, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] a = 32'h0040_5123;
    fill(a, 0, 1, 0, 0, 0, 0, 32'hFFFF_F000, 0, 0, 1, 0);
    look("R7 data read", a, 0, 1, 0, K_HIT, a);
    look("R7 inst read", a, 0, 0, 0, K_HIT, a);
    look("R7 write", a, 0, 1, 1, K_HIT, a);
    look("R14 other mode", a, 1, 1, 0, K_REF, 0);
    look("R2 tag differs", a + 32'h0004_0000, 0, 1, 0, K_REF, 0);
  endtask

  task automatic t_enable;
    write_tc(1, 0);
    look("R13 global entry gone", 32'h0040_5123, 0, 1, 0, K_REF, 0);
  endtask

  task automatic t_resident;
    logic [31:0] b = 32'h1234_8678, c = 32'h0100_2010, d = 32'h0200_3020;
    fill(b, 0, 1, 0, 0, 0, 1, 32'h00AB_C000, 0, 1, 0, 0);
    look("R8 resident read", b, 0, 1, 0, K_HIT, expect_pa(b, 32'h00AB_C000, 0));
    look("R8 resident write", b, 0, 1, 1, K_HIT, expect_pa(b, 32'h00AB_C000, 0));
    fill(c, 0, 1, 0, 0, 0, 1, 32'h0030_0000, 0, 0, 0, 0);
    look("R6 clean read", c, 0, 1, 0, K_HIT, 32'h0030_0010);
    look("R6 clean write", c, 0, 1, 1, K_REF, 0);
    fill(d, 0, 1, 0, 0, 0, 1, 32'h0050_0000, 0, 1, 1, 0);
    look("R5 protected write", d, 0, 1, 1, K_FLT, 0);
    look("R5 protected read", d, 0, 1, 0, K_HIT, 32'h0050_0020);
  endtask

  task automatic t_refused;
    logic [31:0] e = 32'h0300_4000, f = 32'h0300_6000;
    fill(e, 0, 1, 0, 0, 0, 0, 32'h0011_0000, 0, 1, 0, 0);
    look("R9 non-resident", e, 0, 1, 0, K_FLT, 0);
    fill(f, 0, 1, 0, 0, 0, 1, 32'h0012_0000, 0, 1, 0, 1);
    look("R9 supervisor page user fill", f, 0, 1, 0, K_FLT, 0);
    fill(f, 1, 1, 0, 0, 0, 1, 32'h0012_0000, 0, 1, 0, 1);
    look("R9 supervisor page super fill", f, 1, 1, 0, K_HIT, 32'h0012_0000);
  endtask

  task automatic t_transparent;
    logic [31:0] g = 32'h0400_7044, h = 32'h0400_9000;
    fill(g, 0, 1, 1, 0, 1, 0, 32'h0, 0, 0, 0, 0);
    look("R10 window data read", g, 0, 1, 0, K_HIT, g);
    look("R4 window inst fetch", g, 0, 0, 0, K_FLT, 0);
    look("R5 window write", g, 0, 1, 1, K_FLT, 0);
    fill(h, 0, 0, 1, 1, 0, 0, 32'h0, 0, 0, 0, 0);
    look("R10 both types data", h, 0, 1, 0, K_HIT, h);
    look("R10 both types inst", h, 0, 0, 0, K_HIT, h);
    look("R10 window modified", h, 0, 1, 1, K_HIT, h);
  endtask

  task automatic t_flush_idx;
    logic [31:0] i = 32'h0500_A100;
    fill(i, 0, 1, 0, 0, 0, 1, 32'h0060_0000, 0, 1, 0, 0);
    fill(i, 1, 1, 0, 0, 0, 1, 32'h0070_0000, 0, 1, 0, 0);
    look("R14 user entry", i, 0, 1, 0, K_HIT, 32'h0060_0100);
    flush_idx(i, 0, 0);
    look("R11 flushed user", i, 0, 1, 0, K_REF, 0);
    look("R11 super untouched", i, 1, 1, 0, K_HIT, 32'h0070_0100);
  endtask

  task automatic t_global;
    logic [31:0] j = 32'h0600_B000, k = 32'h0600_C000, l = 32'h0600_D000;
    fill(j, 0, 1, 0, 0, 0, 1, 32'h0080_0000, 1, 1, 0, 0);
    fill(k, 0, 1, 0, 0, 0, 1, 32'h0090_0000, 0, 1, 0, 0);
    flush_idx(j, 0, 0);
    look("R12 global kept by index flush", j, 0, 1, 0, K_HIT, 32'h0080_0000);
    flush_all(0);
    look("R12 global kept by full flush", j, 0, 1, 0, K_HIT, 32'h0080_0000);
    look("R12 local removed by full flush", k, 0, 1, 0, K_REF, 0);
    flush_idx(j, 0, 1);
    look("R12 global index flush", j, 0, 1, 0, K_REF, 0);
    fill(l, 0, 1, 0, 0, 0, 1, 32'h00A0_0000, 1, 1, 0, 0);
    flush_all(1);
    look("R12 global full flush", l, 0, 1, 0, K_REF, 0);
  endtask

  task automatic t_big_pages;
    logic [31:0] m = 32'h0700_E000, n = 32'h2000_0234, p = 32'h2000_1234;
    fill(m, 0, 1, 0, 0, 0, 1, 32'h00B0_0000, 1, 1, 0, 0);
    write_tc(1, 1);
    look("R13 tc write removes global", m, 0, 1, 0, K_REF, 0);
    fill(n, 0, 1, 0, 0, 0, 1, 32'h0045_6000, 0, 1, 0, 0);
    fill(p, 0, 1, 0, 0, 0, 1, 32'h0045_6000, 0, 1, 0, 0);
    look("R8 8K low half", n, 0, 1, 0, K_HIT, expect_pa(n, 32'h0045_6000, big));
    look("R8 8K high half", p, 0, 1, 0, K_HIT, expect_pa(p, 32'h0045_6000, big));
    flush_idx(n, 0, 0);
    look("R11 8K flushed index", n, 0, 1, 0, K_REF, 0);
    look("R11 8K paired index", p, 0, 1, 0, K_REF, 0);
    write_tc(1, 0);
    fill(n, 0, 1, 0, 0, 0, 1, 32'h0045_6000, 0, 1, 0, 0);
    fill(p, 0, 1, 0, 0, 0, 1, 32'h0045_6000, 0, 1, 0, 0);
    look("R13 4K page form", p, 0, 1, 0, K_HIT, 32'h0045_6234);
    flush_idx(n, 0, 0);
    look("R11 4K no pairing", p, 0, 1, 0, K_HIT, 32'h0045_6234);
  endtask

  task automatic t_reset_mid;
    logic [31:0] q = 32'h0800_F000;
    fill(q, 1, 1, 0, 0, 0, 1, 32'h00C0_0000, 1, 1, 0, 0);
    look("R1 before reset", q, 1, 1, 0, K_HIT, 32'h00C0_0000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look("R1 global cleared by reset", q, 1, 1, 0, K_REF, 0);
    fill(q, 1, 1, 0, 0, 0, 1, 32'h00C0_0000, 0, 0, 0, 0);
    look("R1 control cleared by reset", q, 1, 1, 1, K_HIT, q);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_disabled();
    t_enable();
    t_resident();
    t_refused();
    t_transparent();
    t_flush_idx();
    t_global();
    t_big_pages();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule